// File: doc/BRIEF.md
# Single-Shot Pulse Width Meter

The block measures how long one input pulse stays high. Once armed, it waits for a rising edge on an asynchronous input. At that edge it clears its results and starts a tick counter of width `CNT_W`. The counter advances once per tick, and a tick lasts `TICK_DIV` system clocks. Each time the counter wraps from all ones to zero, an `OVF_W`-bit wrap count increments. When the falling edge arrives, counting stops and the counter value is held as the remainder. The block then disarms itself and measures nothing more until the next arm strobe.

Software reads the result once `done_o` is high. The pulse width equals (wrap count × 2^CNT_W + remainder) × TICK_DIV clock periods. The wrap count saturates at its maximum, and a sticky overrange flag reports that the count ran out of room. The input passes through a two-stage synchronizer, and edges are found by comparing the newest synchronized sample with the one before it. The defaults are a 16-bit counter, an 8-bit wrap count and a tick every 4 clocks.

Top module: `pulse_width_meter`

## Requirements
- R1: In the armed state, a rising edge on `pulse_i` clears the wrap count, the remainder, `overrange_o` and `done_o`, restarts the tick phase and sets `busy_o`. No other edge starts a measurement.
- R2: While `busy_o` is high, a falling edge stops counting and loads `rem_o` with the counter value, including a tick taken in that same cycle.
- R3: While busy, the wrap count `ovf_cnt_o` increments by one each time the counter steps from all ones to zero. It never decreases during a measurement.
- R4: After a falling edge the block returns to the disarmed state with `busy_o` low. Later pulses leave all outputs unchanged until `arm_i` is pulsed.
- R5: `done_o` rises together with the stop of a measurement and stays high, with `ovf_cnt_o` and `rem_o` stable, until the next measurement starts. `done_o` and `busy_o` are never both high.
- R6: A tick occurs every `TICK_DIV` clocks, counted from the cycle a measurement starts. With a 2-cycle synchronizer, a pulse held high for H clocks reports `ovf_cnt_o`·2^CNT_W + `rem_o` = floor(H / TICK_DIV).
- R7: A wrap that occurs when `ovf_cnt_o` is already all ones leaves the count unchanged and sets `overrange_o`. The flag stays set until the next measurement starts.
- R8: An `arm_i` strobe during a measurement is ignored, and the measurement result is unaffected.
- R9: An `arm_i` strobe while `pulse_i` is already high starts nothing. Only the next true rising edge begins a measurement.
- R10: When a wrap and the falling edge fall in the same tick, the wrap is counted and `rem_o` reads zero.
- R11: After reset the block is disarmed, and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | Asynchronous pulse to measure |
| arm_i | input | 1 | One-cycle strobe that arms the next measurement |
| ovf_cnt_o | output | OVF_W | Number of counter wraps during the pulse |
| rem_o | output | CNT_W | Counter value held at the falling edge |
| done_o | output | 1 | Measurement finished; results valid and stable |
| busy_o | output | 1 | Measurement in progress |
| overrange_o | output | 1 | Sticky flag: the wrap count saturated |

## Verification
The bench targets a wrap that coincides with the falling edge. A design that latches the remainder before counting that wrap reports a result one full counter period short. It drives a pulse long enough to saturate the wrap count; a design that wraps silently shows a small count and no overrange flag. It strobes arm in the middle of a pulse and while the input is already high. A design that honours either strobe restarts the measurement or treats the level as an edge, and the reported width changes. It also sends pulses while the block is disarmed, which a design that fails to disarm would measure, overwriting the held result.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MEAS  = 2'd2
  } meas_state_e;
endpackage

// File: rtl/pwm_sync_edge.sv
module pwm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized sample, sh[STAGES] the previous one
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PW-1:0] ph_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           ph_q <= '0;
        else if (clr_i)        ph_q <= '0;
        else if (ph_q == LAST) ph_q <= '0;
        else                   ph_q <= ph_q + 1'b1;
      end
      assign tick_o = (ph_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pwm_wrap_counter.sv
module pwm_wrap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] nxt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign nxt_o  = cnt_q + {{(CNT_W-1){1'b0}}, en_i};
  assign wrap_o = en_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= nxt_o;
  end
endmodule

// File: rtl/pulse_width_meter.sv
module pulse_width_meter
  import pwm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int OVF_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             arm_i,
  output logic [OVF_W-1:0] ovf_cnt_o,
  output logic [CNT_W-1:0] rem_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             overrange_o
);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  meas_state_e      state_q, state_d;
  logic             rise, fall, tick, start, cnt_en, wrap;
  logic [CNT_W-1:0] cnt_nxt;

  assign start  = (state_q == ST_ARMED) & rise;
  assign cnt_en = (state_q == ST_MEAS) & tick;

  pwm_sync_edge #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pulse_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  pwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start),
    .tick_o(tick)
  );

  pwm_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start),
    .en_i  (cnt_en),
    .nxt_o (cnt_nxt),
    .wrap_o(wrap)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (arm_i) state_d = ST_ARMED;
      ST_ARMED: if (rise)  state_d = ST_MEAS;
      ST_MEAS:  if (fall)  state_d = ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_cnt_o   <= '0;
      rem_o       <= '0;
      done_o      <= 1'b0;
      overrange_o <= 1'b0;
    end else if (start) begin
      ovf_cnt_o   <= '0;
      rem_o       <= '0;
      done_o      <= 1'b0;
      overrange_o <= 1'b0;
    end else if (state_q == ST_MEAS) begin
      if (wrap) begin
        if (ovf_cnt_o == OVF_MAX) overrange_o <= 1'b1;
        else                      ovf_cnt_o   <= ovf_cnt_o + 1'b1;
      end
      // wrap in the stop cycle is already in ovf; rem takes post-tick value
      if (fall) begin
        rem_o  <= cnt_nxt;
        done_o <= 1'b1;
      end
    end
  end

  assign busy_o = (state_q == ST_MEAS);
endmodule

// File: rtl/pulse_width_meter_chk.sv
module pulse_width_meter_chk #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OVF_W-1:0] ovf_cnt_o,
  input logic [CNT_W-1:0] rem_o,
  input logic             done_o,
  input logic             busy_o,
  input logic             overrange_o
);
  // R1
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (ovf_cnt_o == '0 && rem_o == '0 && !overrange_o && !done_o));

  // R3
  ovf_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o -> (ovf_cnt_o >= $past(ovf_cnt_o))));

  // R5
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o -> ($stable(rem_o) && $stable(ovf_cnt_o))));

  // R7
  overrange_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrange_o |-> (&ovf_cnt_o));
endmodule

bind pulse_width_meter pulse_width_meter_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ovf_cnt_o  (ovf_cnt_o),
  .rem_o      (rem_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .overrange_o(overrange_o)
);

// File: tb/pulse_width_meter_test.sv
`timescale 1ns/1ps
module pulse_width_meter_test;
  localparam int CNT_W = 6;
  localparam int OVF_W = 3;
  localparam int DIV   = 2;
  localparam int CMAX  = 1 << CNT_W;
  localparam int OMAX  = (1 << OVF_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pulse = 1'b0;
  logic arm = 1'b0;
  logic [OVF_W-1:0] ovf;
  logic [CNT_W-1:0] rem;
  logic done, busy, orng;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pulse_width_meter #(.CNT_W(CNT_W), .OVF_W(OVF_W), .TICK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pulse_i(pulse), .arm_i(arm),
    .ovf_cnt_o(ovf), .rem_o(rem), .done_o(done), .busy_o(busy), .overrange_o(orng)
  );

  // behavioural reference: 0 idle, 1 armed, 2 measuring
  int m_st, m_cnt, m_ovf, m_rem, m_pre;
  bit m_done, m_orng, p1, p2, p3;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_ovf = 0; m_rem = 0; m_pre = 0;
      m_done = 0; m_orng = 0; p1 = 0; p2 = 0; p3 = 0;
    end else begin
      bit rs, fl, tk, st_start;
      rs = p2 && !p3;
      fl = !p2 && p3;
      tk = (m_pre == DIV - 1);
      st_start = (m_st == 1) && rs;
      case (m_st)
        0: if (arm) m_st = 1;
        1: if (rs) begin
             m_cnt = 0; m_ovf = 0; m_rem = 0; m_orng = 0; m_done = 0; m_st = 2;
           end
        default: begin
          if (tk) begin
            if (m_cnt == CMAX - 1) begin
              if (m_ovf == OMAX) m_orng = 1;
              else m_ovf++;
            end
            m_cnt = (m_cnt + 1) % CMAX;
          end
          if (fl) begin
            m_rem = m_cnt; m_done = 1; m_st = 0;
          end
        end
      endcase
      if (st_start) m_pre = 0;
      else m_pre = tk ? 0 : m_pre + 1;
      p3 = p2; p2 = p1; p1 = pulse;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      check("R3 lockstep ovf", int'(ovf), m_ovf);
      check("R2 lockstep rem", int'(rem), m_rem);
      check("R5 lockstep done", int'(done), int'(m_done));
      check("R4 lockstep busy", int'(busy), int'(m_st == 2));
      check("R7 lockstep overrange", int'(orng), int'(m_orng));
    end
  end

  function automatic int total();
    return int'(ovf) * CMAX + int'(rem);
  endfunction

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic do_pulse(int h);
    @(negedge clk); pulse = 1'b1;
    repeat (h) @(negedge clk);
    pulse = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ovf", int'(ovf), 0);
    check("R11 rem", int'(rem), 0);
    check("R11 done", int'(done), 0);
    check("R11 busy", int'(busy), 0);
    check("R11 overrange", int'(orng), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R4 disarmed after reset: pulse ignored
    do_pulse(10);
    check("R4 unarmed busy", int'(busy), 0);
    check("R4 unarmed total", total(), 0);

    // R1 R6 basic
    do_arm();
    @(negedge clk); pulse = 1'b1;
    repeat (8) @(negedge clk);
    check("R1 busy during pulse", int'(busy), 1);
    check("R5 done low while busy", int'(done), 0);
    repeat (12) @(negedge clk);
    pulse = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 total 20 high", total(), 10);
    check("R5 done after stop", int'(done), 1);

    // R4 no rearm: result unchanged
    do_pulse(30);
    check("R4 held after extra pulse", total(), 10);
    check("R4 busy stays low", int'(busy), 0);

    // R8 arm mid-pulse ignored
    do_arm();
    @(negedge clk); pulse = 1'b1;
    repeat (10) @(negedge clk);
    arm = 1'b1; @(negedge clk); arm = 1'b0;
    repeat (29) @(negedge clk);
    pulse = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 total 40 high", total(), 20);
    check("R4 idle after arm in pulse", int'(busy), 0);

    // R9 arm while input already high
    @(negedge clk); pulse = 1'b1;
    repeat (5) @(negedge clk);
    do_arm();
    repeat (10) @(negedge clk);
    check("R9 no start on level", int'(busy), 0);
    pulse = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 result kept", total(), 20);
    do_pulse(16);
    check("R9 next edge measured", total(), 8);

    // R3 several wraps: 150 ticks
    do_arm();
    do_pulse(300);
    check("R3 ovf count", int'(ovf), 2);
    check("R2 remainder", int'(rem), 22);

    // R10 wrap on stop tick: 64 ticks
    do_arm();
    do_pulse(128);
    check("R10 ovf", int'(ovf), 1);
    check("R10 rem", int'(rem), 0);

    // R7 saturation: 600 ticks
    do_arm();
    do_pulse(1200);
    check("R7 ovf saturated", int'(ovf), OMAX);
    check("R7 overrange set", int'(orng), 1);
    check("R7 rem", int'(rem), 24);
    do_arm();
    do_pulse(4);
    check("R7 overrange cleared", int'(orng), 0);
    check("R1 fresh result", total(), 2);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule